// File: doc/BRIEF.md
# Byte tunnel bridge

This block lets a host with a 32-bit register port reach a small 8-bit register space behind it. The internal space holds the calendar and timer registers. The host never addresses those registers directly. It writes a control word that names one internal byte address, a direction and a set of byte-lane enables, and it then moves the byte through a lower data register. A read is launched by the control write itself. A write is launched by the later write to lower data. Each internal transfer takes a fixed number of cycles, and a busy bit in the control word stays high for that whole window.

The bridge also keeps a two-bit interrupt enable register and a matching flag register. One flag bit catches the interrupt line of the internal subsystem. The other flag bit records that the bridge finished a transfer. The interrupt output is high when any flag is set while its enable bit is also set. Software polls busy, or waits for the completion flag, before it reads a fetched byte or starts the next access.

Top module: `byte_tunnel_bridge`

## Requirements
- R1: After reset the following are zero: the control fields, lower data, upper data, the enable bits and the flag bits. Busy and irq are low. Reading the identification slot returns the constant parameter `IdValue`.
- R2: Host byte offsets decode as follows: 0x00 identification, 0x04 control, 0x08 lower data, 0x0C upper data, 0x10 interrupt enable, 0x14 interrupt flag. An offset that is not a multiple of four writes nothing and reads zero. The control word reads back with the following layout: bit 31 busy, bit 25 size, bit 24 direction (1 means read), bits 23:20 upper lane enables, bits 19:16 lower lane enables, bits 7:0 internal address. All other bits read zero. The size bit and the upper lane enables are only stored.
- R3: A control write with bit 24 set and bit 16 set starts an internal read. Busy is high for exactly `Latency` cycles. In the last of those cycles `regRe` pulses for one cycle with `regAddr` equal to the stored address. When busy drops, lower data holds the returned byte in bits 7:0 and zeros in bits 31:8.
- R4: A write to lower data starts an internal write when the stored control has bit 24 clear and bit 16 set. Busy is high for exactly `Latency` cycles. In the last of those cycles `regWe` pulses for one cycle, with `regAddr` equal to the stored address and `regWdata` equal to bits 7:0 of lower data. `regWe` and `regRe` are never high together.
- R5: When lower lane enable bit 16 is clear, no transfer starts. This holds for both a read-direction control write and a lower data write. The written word is still stored.
- R6: While busy is high, host writes to control and to lower data are ignored. The stored control, the stored lower data and the internal registers are left unchanged.
- R7: Upper data is plain 32-bit storage. Writing it never starts a transfer.
- R8: Flag bit 1 is set in every cycle in which `subIrq` is high. Flag bit 0 is set in the cycle after a transfer completes.
- R9: Writing 1 to a flag bit clears it, and writing 0 to it has no effect. A set event in the same cycle as the clear wins.
- R10: `irq` is high exactly when some flag bit is set and its enable bit is also set. The enable bits sit at bits 1:0 of the enable register, with the same positions as in the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWe | input | 1 | Host write strobe, one beat per cycle |
| hostAddr | input | 5 | Host byte offset |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data for `hostAddr`, combinational |
| regAddr | output | RegAw | Internal register address |
| regWdata | output | RegDw | Internal write byte |
| regWe | output | 1 | Internal write pulse |
| regRe | output | 1 | Internal read pulse; `regRdata` is sampled at the same edge |
| regRdata | input | RegDw | Internal read byte |
| subIrq | input | 1 | Interrupt line from the internal subsystem |
| irq | output | 1 | Combined interrupt request |

## Verification
The bound checker watches several rules on every clock:
- The internal strobes only appear inside a busy window, and they never overlap.
- Every busy window lasts exactly `Latency` cycles and ends with a strobe.
- A control write made during busy leaves the stored control word unchanged.
- Both flag sources latch on the cycle after their event.

The bench's scenarios, compared cycle by cycle against a behavioural model, are needed for the rest:
- the byte that actually lands in lower data after a read;
- the gating by lower lane enable bit 0;
- the fact that a data write during busy never reaches the internal space;
- the write-one-to-clear ordering against a simultaneous set;
- the control readback layout.

// File: rtl/byte_tunnel_pkg.sv
`timescale 1ns/1ps
package byte_tunnel_pkg;
  localparam int HostAw = 5;
  localparam int SlotW  = 3;

  localparam logic [SlotW-1:0] SlotId   = 3'd0;
  localparam logic [SlotW-1:0] SlotCtl  = 3'd1;
  localparam logic [SlotW-1:0] SlotLow  = 3'd2;
  localparam logic [SlotW-1:0] SlotUpp  = 3'd3;
  localparam logic [SlotW-1:0] SlotIen  = 3'd4;
  localparam logic [SlotW-1:0] SlotFlag = 3'd5;

  localparam int BusyBit = 31;
  localparam int SizeBit = 25;
  localparam int DirBit  = 24;
  localparam int UbenLo  = 20;
  localparam int LbenLo  = 16;
  localparam int NumSrc  = 2;   // bit 1 subsystem, bit 0 bridge completion

  typedef struct packed {
    logic ctlWr;
    logic lowWr;
    logic uppWr;
    logic ienWr;
    logic flagWr;
    logic done;
    logic doneRead;
  } strobe_t;
endpackage

// File: rtl/byte_tunnel_ctrl.sv
`timescale 1ns/1ps
module byte_tunnel_ctrl import byte_tunnel_pkg::*; #(
  parameter int Latency = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWe,
  input  logic [SlotW-1:0] hostSlot,
  input  logic             hostAligned,
  input  logic             wrDir,
  input  logic             wrBen0,
  input  logic             ctlDir,
  input  logic             ctlBen0,
  output strobe_t          stb,
  output logic             busy,
  output logic             regWe,
  output logic             regRe
);
  localparam int CntW = $clog2(Latency + 1);

  logic [CntW-1:0] left;
  logic            pendRead;
  logic            hit;
  logic            finish;
  logic            launchRd;
  logic            launchWr;

  assign hit = hostWe && hostAligned;

  always_comb begin
    stb          = '0;
    stb.ctlWr    = hit && (hostSlot == SlotCtl) && !busy;
    stb.lowWr    = hit && (hostSlot == SlotLow) && !busy;
    stb.uppWr    = hit && (hostSlot == SlotUpp);
    stb.ienWr    = hit && (hostSlot == SlotIen);
    stb.flagWr   = hit && (hostSlot == SlotFlag);
    finish       = busy && (left == CntW'(1));
    stb.done     = finish;
    stb.doneRead = finish && pendRead;
  end

  assign launchRd = stb.ctlWr && wrDir && wrBen0;
  assign launchWr = stb.lowWr && !ctlDir && ctlBen0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      left     <= '0;
      pendRead <= 1'b0;
    end else if (launchRd || launchWr) begin
      busy     <= 1'b1;
      left     <= CntW'(Latency);
      pendRead <= launchRd;
    end else if (finish) begin
      busy     <= 1'b0;
      left     <= '0;
    end else if (busy) begin
      left     <= left - CntW'(1);
    end
  end

  assign regWe = finish && !pendRead;
  assign regRe = stb.doneRead;
endmodule

// File: rtl/byte_tunnel_dpath.sv
`timescale 1ns/1ps
module byte_tunnel_dpath import byte_tunnel_pkg::*; #(
  parameter int          RegAw   = 8,
  parameter int          RegDw   = 8,
  parameter logic [31:0] IdValue = 32'h4E1B_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [SlotW-1:0]  hostSlot,
  input  logic              hostAligned,
  input  logic [31:0]       hostWdata,
  input  logic              busy,
  input  logic [RegDw-1:0]  regRdata,
  input  logic              subIrq,
  output logic [31:0]       hostRdata,
  output logic [RegAw-1:0]  regAddr,
  output logic [RegDw-1:0]  regWdata,
  output logic              ctlDir,
  output logic              ctlBen0,
  output logic [31:0]       ctlWord,
  output logic [NumSrc-1:0] flagQ,
  output logic              irq
);
  logic             ctlSize;
  logic [3:0]       ctlUben;
  logic [3:0]       ctlLben;
  logic [RegAw-1:0] ctlAddr;
  logic [31:0]      lowData;
  logic [31:0]      uppData;
  logic [NumSrc-1:0] ienQ;
  logic [NumSrc-1:0] srcHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlSize <= 1'b0;
      ctlDir  <= 1'b0;
      ctlUben <= '0;
      ctlLben <= '0;
      ctlAddr <= '0;
    end else if (stb.ctlWr) begin
      ctlSize <= hostWdata[SizeBit];
      ctlDir  <= hostWdata[DirBit];
      ctlUben <= hostWdata[UbenLo +: 4];
      ctlLben <= hostWdata[LbenLo +: 4];
      ctlAddr <= hostWdata[RegAw-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowData <= '0;
      uppData <= '0;
      ienQ    <= '0;
    end else begin
      if (stb.lowWr)         lowData <= hostWdata;
      else if (stb.doneRead) lowData <= {{(32-RegDw){1'b0}}, regRdata};
      if (stb.uppWr)         uppData <= hostWdata;
      if (stb.ienWr)         ienQ    <= hostWdata[NumSrc-1:0];
    end
  end

  // Each source sets its flag; a host write of 1 clears it unless a set arrives too.
  assign srcHit = {subIrq, stb.done};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
    end else begin
      for (int i = 0; i < NumSrc; i++) begin
        if (srcHit[i])                         flagQ[i] <= 1'b1;
        else if (stb.flagWr && hostWdata[i])   flagQ[i] <= 1'b0;
      end
    end
  end

  assign irq      = |(flagQ & ienQ);
  assign ctlBen0  = ctlLben[0];
  assign regAddr  = ctlAddr;
  assign regWdata = lowData[RegDw-1:0];
  assign ctlWord  = {6'b0, ctlSize, ctlDir, ctlUben, ctlLben, 8'b0, 8'(ctlAddr)};

  always_comb begin
    hostRdata = '0;
    if (hostAligned) begin
      case (hostSlot)
        SlotId:   hostRdata = IdValue;
        SlotCtl:  hostRdata = {busy, ctlWord[BusyBit-1:0]};
        SlotLow:  hostRdata = lowData;
        SlotUpp:  hostRdata = uppData;
        SlotIen:  hostRdata = {{(32-NumSrc){1'b0}}, ienQ};
        SlotFlag: hostRdata = {{(32-NumSrc){1'b0}}, flagQ};
        default:  hostRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/byte_tunnel_bridge.sv
`timescale 1ns/1ps
module byte_tunnel_bridge import byte_tunnel_pkg::*; #(
  parameter int          Latency = 4,
  parameter int          RegAw   = 8,
  parameter int          RegDw   = 8,
  parameter logic [31:0] IdValue = 32'h4E1B_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [HostAw-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic [RegAw-1:0]  regAddr,
  output logic [RegDw-1:0]  regWdata,
  output logic              regWe,
  output logic              regRe,
  input  logic [RegDw-1:0]  regRdata,
  input  logic              subIrq,
  output logic              irq
);
  strobe_t           stb;
  logic [SlotW-1:0]  hostSlot;
  logic              hostAligned;
  logic              busy;
  logic              ctlDir;
  logic              ctlBen0;
  logic [31:0]       ctlWord;
  logic [NumSrc-1:0] flagQ;

  assign hostSlot    = hostAddr[HostAw-1:2];
  assign hostAligned = (hostAddr[1:0] == 2'b00);

  byte_tunnel_ctrl #(.Latency(Latency)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostSlot(hostSlot),
    .hostAligned(hostAligned), .wrDir(hostWdata[DirBit]),
    .wrBen0(hostWdata[LbenLo]), .ctlDir(ctlDir), .ctlBen0(ctlBen0),
    .stb(stb), .busy(busy), .regWe(regWe), .regRe(regRe)
  );

  byte_tunnel_dpath #(.RegAw(RegAw), .RegDw(RegDw), .IdValue(IdValue)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .hostSlot(hostSlot),
    .hostAligned(hostAligned), .hostWdata(hostWdata), .busy(busy),
    .regRdata(regRdata), .subIrq(subIrq), .hostRdata(hostRdata),
    .regAddr(regAddr), .regWdata(regWdata), .ctlDir(ctlDir),
    .ctlBen0(ctlBen0), .ctlWord(ctlWord), .flagQ(flagQ), .irq(irq)
  );
endmodule

// File: rtl/byte_tunnel_checker.sv
`timescale 1ns/1ps
module byte_tunnel_checker import byte_tunnel_pkg::*; #(
  parameter int Latency = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWe,
  input logic [SlotW-1:0]  hostSlot,
  input logic              hostAligned,
  input logic              busy,
  input logic              regWe,
  input logic              regRe,
  input logic              subIrq,
  input logic [31:0]       ctlWord,
  input logic [NumSrc-1:0] flagQ
);
  logic [15:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runLen <= '0;
    else if (busy) runLen <= runLen + 16'd1;
    else           runLen <= '0;
  end

  assert_strobe_in_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWe || regRe) |-> busy);

  assert_exclusive_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regRe));

  assert_busy_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == 16'(Latency)) && $past(regWe || regRe));

  assert_ignore_ctl_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && hostWe && hostAligned && hostSlot == SlotCtl) |=> (ctlWord == $past(ctlWord)));

  assert_sub_latch_R8: assert property (@(posedge clk) disable iff (!rstN)
    subIrq |=> flagQ[1]);

  assert_done_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWe || regRe) |=> flagQ[0]);
endmodule

bind byte_tunnel_bridge byte_tunnel_checker #(.Latency(Latency)) u_check (
  .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostSlot(hostSlot),
  .hostAligned(hostAligned), .busy(busy), .regWe(regWe), .regRe(regRe),
  .subIrq(subIrq), .ctlWord(ctlWord), .flagQ(flagQ)
);

// File: tb/byte_tunnel_bridge_bench.sv
`timescale 1ns/1ps
module byte_tunnel_bridge_bench;
  localparam int          Lat = 4;
  localparam logic [31:0] Id  = 32'h4E1B_0001;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWe = 1'b0;
  logic [4:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic [7:0]  regAddr, regWdata, regRdata;
  logic        regWe, regRe, irq;
  logic        subIrq = 1'b0;

  int nChecks = 0;
  int nFail = 0;

  logic [7:0] regFile [256];

  always #5 clk = ~clk;

  byte_tunnel_bridge #(.Latency(Lat), .RegAw(8), .RegDw(8), .IdValue(Id)) u_byte_tunnel_bridge (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .regAddr(regAddr),
    .regWdata(regWdata), .regWe(regWe), .regRe(regRe), .regRdata(regRdata),
    .subIrq(subIrq), .irq(irq)
  );

  // Internal register space stand-in
  assign regRdata = regFile[regAddr];
  always @(posedge clk) if (regWe) regFile[regAddr] <= regWdata;

  // Behavioural reference model
  int          mLeft = 0;
  bit          mRead = 0;
  logic [31:0] mCtl = '0, mLow = '0, mUpp = '0;
  logic [1:0]  mIen = '0, mFlag = '0, nFlag;
  logic [2:0]  slotN;
  bit          fin, wOk;

  always @(posedge clk) begin
    if (!rstN) begin
      mLeft = 0; mRead = 0; mCtl = '0; mLow = '0; mUpp = '0; mIen = '0; mFlag = '0;
    end else begin
      fin   = (mLeft == 1);
      slotN = hostAddr[4:2];
      wOk   = hostWe && (hostAddr[1:0] == 2'b00);
      nFlag = mFlag;
      if (wOk && slotN == 3'd5) nFlag = nFlag & ~hostWdata[1:0];
      if (subIrq) nFlag[1] = 1'b1;
      if (fin)    nFlag[0] = 1'b1;
      if (wOk && slotN == 3'd3) mUpp = hostWdata;
      if (wOk && slotN == 3'd4) mIen = hostWdata[1:0];
      if (fin) begin
        if (mRead) mLow = {24'h0, regFile[mCtl[7:0]]};
        mLeft = 0;
      end else if (mLeft > 0) begin
        mLeft = mLeft - 1;
      end else begin
        if (wOk && slotN == 3'd1) begin
          mCtl = hostWdata & 32'h03FF_00FF;
          if (hostWdata[24] && hostWdata[16]) begin mLeft = Lat; mRead = 1; end
        end
        if (wOk && slotN == 3'd2) begin
          mLow = hostWdata;
          if (!mCtl[24] && mCtl[16]) begin mLeft = Lat; mRead = 0; end
        end
      end
      mFlag = nFlag;
    end
  end

  function automatic logic [31:0] modelRead(input logic [2:0] s);
    case (s)
      3'd0: return Id;
      3'd1: return ((mLeft > 0) ? 32'h8000_0000 : 32'h0) | mCtl;
      3'd2: return mLow;
      3'd3: return mUpp;
      3'd4: return {30'h0, mIen};
      3'd5: return {30'h0, mFlag};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string slotTag(input logic [2:0] s);
    case (s)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R7";
      3'd4: return "R10";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      check(regWe === (mLeft == 1 && !mRead), "R4", 32'(regWe), 32'(mLeft == 1 && !mRead));
      check(regRe === (mLeft == 1 && mRead), "R3", 32'(regRe), 32'(mLeft == 1 && mRead));
      if (regWe || regRe) check(regAddr === mCtl[7:0], "R3", 32'(regAddr), 32'(mCtl[7:0]));
      if (regWe) check(regWdata === mLow[7:0], "R4", 32'(regWdata), 32'(mLow[7:0]));
      check(irq === |(mFlag & mIen), "R10", 32'(irq), 32'(|(mFlag & mIen)));
      check(hostRdata === modelRead(hostAddr[4:2]), slotTag(hostAddr[4:2]),
            hostRdata, modelRead(hostAddr[4:2]));
    end
  end

  task automatic hostWrite(input logic [2:0] s, input logic [31:0] d);
    @(posedge clk); #1;
    hostWe = 1'b1; hostAddr = {s, 2'b00}; hostWdata = d;
    @(posedge clk); #1;
    hostWe = 1'b0;
  endtask

  task automatic peek(input logic [2:0] s, output logic [31:0] v);
    hostAddr = {s, 2'b00};
    @(negedge clk);
    v = hostRdata;
  endtask

  task automatic waitIdle();
    hostAddr = 5'h04;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (!hostRdata[31]) break;
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 256; i++) regFile[i] = 8'h00;
    regFile[8'h40] = 8'h3C;
    repeat (3) @(posedge clk); #1;
    rstN = 1'b1;

    // R1: reset state
    peek(3'd0, v); check(v === Id, "R1", v, Id);
    peek(3'd1, v); check(v === 32'h0, "R1", v, 32'h0);
    peek(3'd5, v); check(v === 32'h0, "R1", v, 32'h0);
    check(irq === 1'b0, "R1", 32'(irq), 32'h0);

    // R4: tunnelled write of 0xA5 to address 0x23
    hostWrite(3'd1, 32'h0001_0023);
    hostWrite(3'd2, 32'h0000_00A5);
    waitIdle();
    check(regFile[8'h23] === 8'hA5, "R4", 32'(regFile[8'h23]), 32'hA5);
    peek(3'd5, v); check(v[0] === 1'b1, "R8", v, 32'h1);

    // R3: tunnelled read of address 0x40
    hostWrite(3'd1, 32'h0101_0040);
    waitIdle();
    peek(3'd2, v); check(v === 32'h0000_003C, "R3", v, 32'h3C);

    // R5: lower enable bit clear starts nothing
    hostWrite(3'd1, 32'h0100_0040);
    peek(3'd1, v); check(v === 32'h0100_0040, "R5", v, 32'h0100_0040);
    hostWrite(3'd1, 32'h0000_0011);
    hostWrite(3'd2, 32'h0000_0077);
    peek(3'd1, v); check(v[31] === 1'b0, "R5", v, 32'h0000_0011);
    check(regFile[8'h11] === 8'h00, "R5", 32'(regFile[8'h11]), 32'h0);

    // R6: control and data writes during busy are dropped
    hostWrite(3'd1, 32'h0001_0030);
    hostWrite(3'd2, 32'h0000_0011);
    hostWrite(3'd1, 32'h0101_0099);
    hostWrite(3'd2, 32'h0000_0055);
    waitIdle();
    check(regFile[8'h30] === 8'h11, "R6", 32'(regFile[8'h30]), 32'h11);
    peek(3'd1, v); check(v === 32'h0001_0030, "R6", v, 32'h0001_0030);
    peek(3'd2, v); check(v === 32'h0000_0011, "R6", v, 32'h11);

    // R7: upper data is plain storage
    hostWrite(3'd3, 32'hDEAD_BEEF);
    peek(3'd3, v); check(v === 32'hDEAD_BEEF, "R7", v, 32'hDEAD_BEEF);
    peek(3'd1, v); check(v[31] === 1'b0, "R7", v, 32'h0001_0030);

    // R2: control layout drops unmapped bits
    hostWrite(3'd1, 32'h7EFE_FF12);
    peek(3'd1, v); check(v === 32'h02FE_0012, "R2", v, 32'h02FE_0012);

    // R8, R9, R10: flags, enables and clearing
    hostWrite(3'd5, 32'h0000_0003);
    peek(3'd5, v); check(v === 32'h0, "R9", v, 32'h0);
    @(posedge clk); #1 subIrq = 1'b1;
    @(posedge clk); #1 subIrq = 1'b0;
    peek(3'd5, v); check(v === 32'h2, "R8", v, 32'h2);
    check(irq === 1'b0, "R10", 32'(irq), 32'h0);
    hostWrite(3'd4, 32'h0000_0002);
    peek(3'd4, v); check(irq === 1'b1, "R10", 32'(irq), 32'h1);
    subIrq = 1'b1;
    hostWrite(3'd5, 32'h0000_0002);
    subIrq = 1'b0;
    peek(3'd5, v); check(v === 32'h2, "R9", v, 32'h2);
    hostWrite(3'd5, 32'h0000_0002);
    peek(3'd5, v); check(v === 32'h0, "R9", v, 32'h0);
    check(irq === 1'b0, "R10", 32'(irq), 32'h0);

    repeat (4) @(posedge clk);
    finishRun();
  end
endmodule